// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the arithmetic and logic stage of a 32-bit integer datapath. It takes two register operands, a 16-bit instruction immediate with a flag that selects the immediate as the second operand, a 5-bit shift field and a 4-bit operation code. In the same cycle it returns a result and a write enable for the destination register. Reading and writing the register file, and acting on the trap, are the job of the surrounding pipeline.

Signed addition and subtraction check for two's-complement overflow. When one occurs, the block withholds the write enable so the destination keeps its old value. It also raises a registered trap flag on the following clock edge. The unsigned forms produce the same bit pattern and never trap. Arithmetic and compare immediates are sign-extended. The bitwise immediates are zero-extended.

Top module: `int_alu_trap`

## Requirements
- R1: Codes 0 (signed add), 1 (unsigned add), 2 (signed subtract) and 3 (unsigned subtract) put op_a plus or minus the second operand, modulo 2^32, on result. The second operand is op_b when use_imm is 0. When use_imm is 1 it is imm sign-extended to 32 bits.
- R2: For codes 0 and 2, wr_en is 0 in the same cycle when signed overflow occurs. Overflow means the two addends have equal sign bits and the result's sign bit differs, where subtraction adds the negated second operand. Otherwise wr_en is 1.
- R3: ovf_trap is 1 in the cycle after a signed add or subtract overflowed, and 0 after any other operation.
- R4: Codes 1 and 3 always assert wr_en and never raise ovf_trap, even when the signed interpretation would overflow.
- R5: Code 4 (AND) and code 5 (OR) are bitwise. With use_imm at 1 the immediate is zero-extended.
- R6: Code 6 compares signed and code 7 compares unsigned. Result is 1 when op_a is below the second operand and 0 otherwise. An immediate second operand is sign-extended for both codes.
- R7: Codes 8 (left), 9 (logical right) and 10 (arithmetic right) shift op_b by shamt. Left and logical right shifts fill with zeros. Arithmetic right shifts fill with op_b bit 31.
- R8: Codes 11 (left), 12 (logical right) and 13 (arithmetic right) shift op_b by op_a[4:0]. The upper bits of op_a have no effect.
- R9: Code 14 puts imm in result[31:16] and zeros in result[15:0], with wr_en at 1.
- R10: Code 15 is reserved. It gives result 0 and wr_en 0.
- R11: While rst_n is low, ovf_trap is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the trap register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select (codes in R1-R10) |
| op_a | input | 32 | First operand; register shift amount in bits 4:0 |
| op_b | input | 32 | Second operand; value being shifted |
| imm | input | 16 | Instruction immediate |
| use_imm | input | 1 | 1 selects the extended immediate as second operand |
| shamt | input | 5 | Instruction shift amount |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| ovf_trap | output | 1 | Registered overflow exception flag |

## Verification
Almost all of the block is combinational. A wrong operand extension, shift fill or compare form shows up on result in the same cycle as the stimulus, so the bench checks result and wr_en a fraction of a cycle after driving the inputs. The only state is the trap register. A stuck or misrouted trap appears one edge after the overflowing operation, and the bench confirms it clears again one edge after a clean one. Overflow corners are probed at both extremes of the signed range, for add and for subtract.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_SLT  = 4'd6,
    OP_SLTU = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_SLLV = 4'd11,
    OP_SRLV = 4'd12,
    OP_SRAV = 4'd13,
    OP_LUI  = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     reg_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             zero_ext,
  output logic [W-1:0]     opnd_b
);
  localparam int EXT_W = W - IMM_W;
  logic [EXT_W-1:0] ext_bits;

  always_comb begin
    ext_bits = zero_ext ? '0 : {EXT_W{imm[IMM_W-1]}};
    opnd_b   = use_imm ? {ext_bits, imm} : reg_b;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = do_sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, do_sub};
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    value,
  input  logic [SH_W-1:0] amt,
  input  logic            to_left,
  input  logic            arith,
  output logic [W-1:0]    shifted
);
  logic         fill;
  logic [W-1:0] stg [0:SH_W];
  logic [W-1:0] pre;
  logic [W-1:0] post;

  always_comb begin
    for (int i = 0; i < W; i++) pre[i] = to_left ? value[W-1-i] : value[i];
    fill = arith & ~to_left & value[W-1];
  end

  assign stg[0] = pre;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
  end

  always_comb begin
    post = stg[SH_W];
    for (int i = 0; i < W; i++) shifted[i] = to_left ? post[W-1-i] : post[i];
  end
endmodule

// File: rtl/int_alu_trap.sv
module int_alu_trap
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_code,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic [SH_W-1:0]  shamt,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic             ovf_trap
);
  localparam int LO_W = W - IMM_W;

  alu_op_e         op;
  logic [W-1:0]    opnd_b;
  logic [W-1:0]    sum;
  logic            add_ovf;
  logic [W-1:0]    sh_out;
  logic [SH_W-1:0] sh_amt;
  logic            is_logic, is_sub, is_signed_arith, is_var_shift;
  logic            trap_d, trap_q;

  assign op = alu_op_e'(op_code);

  always_comb begin
    is_logic        = (op == OP_AND) || (op == OP_OR);
    is_sub          = (op == OP_SUB) || (op == OP_SUBU);
    is_signed_arith = (op == OP_ADD) || (op == OP_SUB);
    is_var_shift    = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
    sh_amt          = is_var_shift ? op_a[SH_W-1:0] : shamt;
  end

  alu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_opsel (
    .reg_b   (op_b),
    .imm     (imm),
    .use_imm (use_imm),
    .zero_ext(is_logic),
    .opnd_b  (opnd_b)
  );

  alu_addsub #(.W(W)) u_addsub (
    .a     (op_a),
    .b     (opnd_b),
    .do_sub(is_sub),
    .sum   (sum),
    .ovf   (add_ovf)
  );

  alu_shifter #(.W(W), .SH_W(SH_W)) u_shift (
    .value  (op_b),
    .amt    (sh_amt),
    .to_left((op == OP_SLL) || (op == OP_SLLV)),
    .arith  ((op == OP_SRA) || (op == OP_SRAV)),
    .shifted(sh_out)
  );

  always_comb begin
    result = '0;
    wr_en  = 1'b1;
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = sum;
      OP_AND:  result = op_a & opnd_b;
      OP_OR:   result = op_a | opnd_b;
      OP_SLT:  result = {{(W-1){1'b0}}, ($signed(op_a) < $signed(opnd_b))};
      OP_SLTU: result = {{(W-1){1'b0}}, (op_a < opnd_b)};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: result = sh_out;
      OP_LUI:  result = {imm, {LO_W{1'b0}}};
      default: begin
        result = '0;
        wr_en  = 1'b0;
      end
    endcase
    if (is_signed_arith && add_ovf) wr_en = 1'b0;
    trap_d = is_signed_arith && add_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign ovf_trap = trap_q;

  // R3: a raised trap must trace back to a withheld signed add/sub write
  assert_trap_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> ($past(!wr_en) && ($past(op_code) == 4'd0 || $past(op_code) == 4'd2)));

  // R4: unsigned add/sub always write
  assert_unsigned_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd1 || op_code == 4'd3) |-> wr_en);

  // R6: compare results are single-bit booleans
  assert_cmp_bool_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd6 || op_code == 4'd7) |-> (result[W-1:1] == '0 && wr_en));

  // R9: upper-immediate load clears the low half and writes
  assert_upper_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd14) |-> (result[LO_W-1:0] == '0 && result[W-1:LO_W] == imm && wr_en));

  // R10: reserved code writes nothing
  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd15) |-> (!wr_en && result == '0));

  // R2: a withheld write comes only from signed arithmetic or the reserved code
  assert_no_write_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (op_code == 4'd0 || op_code == 4'd2 || op_code == 4'd15));
endmodule

// File: tb/sim_int_alu_trap.sv
module sim_int_alu_trap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_code;
  logic [31:0] op_a, op_b;
  logic [15:0] imm;
  logic        use_imm;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        wr_en;
  logic        ovf_trap;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  int_alu_trap u0 (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_a(op_a), .op_b(op_b),
    .imm(imm), .use_imm(use_imm), .shamt(shamt),
    .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i, input logic ui, input logic [4:0] s);
    @(negedge clk);
    op_code = c; op_a = a; op_b = b; imm = i; use_imm = ui; shamt = s;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(4'd0, 32'h7fffffff, 32'h1, 16'h0, 1'b0, 5'd0);
    @(posedge clk); #1;
    chk("R11 trap low in reset", {31'b0, ovf_trap}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    drive(4'd1, 32'h0, 32'h0, 16'h0, 1'b0, 5'd0);
    @(posedge clk); #1;
  endtask

  task automatic t_addsub();
    drive(4'd0, 32'd5, 32'd7, 16'h0, 1'b0, 5'd0);
    chk("R1 add", result, 32'd12);
    drive(4'd1, 32'hffffffff, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R1 addu wrap", result, 32'h0);
    drive(4'd2, 32'd3, 32'd5, 16'h0, 1'b0, 5'd0);
    chk("R1 sub", result, 32'hfffffffe);
    drive(4'd0, 32'd10, 32'd0, 16'hffff, 1'b1, 5'd0);
    chk("R1 add sign-ext imm", result, 32'd9);
    drive(4'd3, 32'd1, 32'd0, 16'h8000, 1'b1, 5'd0);
    chk("R1 subu sign-ext imm", result, 32'h00008001);
  endtask

  task automatic t_overflow();
    drive(4'd0, 32'h7fffffff, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R2 add ovf wr_en", {31'b0, wr_en}, 32'h0);
    @(posedge clk); #1;
    chk("R3 trap after add ovf", {31'b0, ovf_trap}, 32'h1);
    drive(4'd0, 32'hffffffff, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R2 add no ovf wr_en", {31'b0, wr_en}, 32'h1);
    @(posedge clk); #1;
    chk("R3 trap clears", {31'b0, ovf_trap}, 32'h0);
    drive(4'd2, 32'h80000000, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R2 sub ovf low", {31'b0, wr_en}, 32'h0);
    drive(4'd2, 32'h0, 32'h80000000, 16'h0, 1'b0, 5'd0);
    chk("R2 sub ovf neg-min", {31'b0, wr_en}, 32'h0);
    @(posedge clk); #1;
    chk("R3 trap after sub ovf", {31'b0, ovf_trap}, 32'h1);
    drive(4'd0, 32'h7fff0000, 32'd0, 16'h7fff, 1'b1, 5'd0);
    chk("R2 addi no ovf", {31'b0, wr_en}, 32'h1);
  endtask

  task automatic t_unsigned();
    drive(4'd1, 32'h7fffffff, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R4 addu result", result, 32'h80000000);
    chk("R4 addu wr_en", {31'b0, wr_en}, 32'h1);
    @(posedge clk); #1;
    chk("R4 addu no trap", {31'b0, ovf_trap}, 32'h0);
    drive(4'd3, 32'h80000000, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R4 subu wr_en", {31'b0, wr_en}, 32'h1);
    @(posedge clk); #1;
    chk("R4 subu no trap", {31'b0, ovf_trap}, 32'h0);
  endtask

  task automatic t_logic();
    drive(4'd4, 32'hffffffff, 32'h0, 16'h8000, 1'b1, 5'd0);
    chk("R5 and zero-ext imm", result, 32'h00008000);
    drive(4'd5, 32'hf0f00000, 32'h0000ff00, 16'h0, 1'b0, 5'd0);
    chk("R5 or reg", result, 32'hf0f0ff00);
    drive(4'd5, 32'h12340000, 32'h0, 16'hffff, 1'b1, 5'd0);
    chk("R5 or zero-ext imm", result, 32'h1234ffff);
  endtask

  task automatic t_compare();
    drive(4'd6, 32'hffffffff, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R6 slt signed", result, 32'd1);
    drive(4'd7, 32'hffffffff, 32'd1, 16'h0, 1'b0, 5'd0);
    chk("R6 sltu unsigned", result, 32'd0);
    drive(4'd7, 32'd5, 32'h0, 16'hffff, 1'b1, 5'd0);
    chk("R6 sltu sign-ext imm", result, 32'd1);
    drive(4'd6, 32'd5, 32'h0, 16'hffff, 1'b1, 5'd0);
    chk("R6 slt imm", result, 32'd0);
  endtask

  task automatic t_shift();
    drive(4'd8, 32'h0, 32'd1, 16'h0, 1'b0, 5'd31);
    chk("R7 sll", result, 32'h80000000);
    drive(4'd10, 32'h0, 32'h80000000, 16'h0, 1'b0, 5'd4);
    chk("R7 sra", result, 32'hf8000000);
    drive(4'd9, 32'h0, 32'h80000000, 16'h0, 1'b0, 5'd4);
    chk("R7 srl", result, 32'h08000000);
    drive(4'd11, 32'h00000021, 32'd3, 16'h0, 1'b0, 5'd7);
    chk("R8 sllv low bits", result, 32'd6);
    drive(4'd13, 32'hffffffe4, 32'h80000000, 16'h0, 1'b0, 5'd0);
    chk("R8 srav", result, 32'hf8000000);
    drive(4'd12, 32'hffffffe4, 32'h80000000, 16'h0, 1'b0, 5'd0);
    chk("R8 srlv", result, 32'h08000000);
  endtask

  task automatic t_upper_rsvd();
    drive(4'd14, 32'hffffffff, 32'hffffffff, 16'habcd, 1'b0, 5'd0);
    chk("R9 upper load", result, 32'habcd0000);
    chk("R9 upper wr_en", {31'b0, wr_en}, 32'h1);
    drive(4'd15, 32'hffffffff, 32'hffffffff, 16'hffff, 1'b1, 5'd3);
    chk("R10 reserved result", result, 32'h0);
    chk("R10 reserved wr_en", {31'b0, wr_en}, 32'h0);
  endtask

  initial begin
    op_code = 4'd0; op_a = '0; op_b = '0; imm = '0; use_imm = 1'b0; shamt = '0;
    t_reset();
    t_addsub();
    t_overflow();
    t_unsigned();
    t_logic();
    t_compare();
    t_shift();
    t_upper_rsvd();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule